// File: doc/BRIEF.md
# DMA Buffer Position Tracker

This block keeps track of how far a DMA engine has progressed through the memory buffer of its current descriptor. Each channel has two registers that the processor can read but not write. One holds the current buffer address and the other holds the bytes still to move. A descriptor read loads both registers. The registers are not updated on every data beat. Instead, at the start of a transaction the selected channel's values are copied into one shared pair of working counters. The counters advance with each completed beat, and when the transaction ends they are written back to that channel's registers.

Because there is only one pair of counters, the channels can take turns on it, such as several logical transmit or receive streams served in time slices. The number of channels is a parameter. Transmit and receive each get their own instance. A one-cycle pulse, together with a channel number, reports the write-back that leaves a buffer fully consumed. Bus arbitration and descriptor fetching happen elsewhere.

Top module: `bufpos_tracker`

## Requirements
- R1: During and after reset, every channel's address and length registers read 0, `txnActive` is 0 and `descDone` is 0.
- R2: When `descLoad` is high at a clock edge, `descAddr` and `descLen` go into the registers of channel `descCh` and are visible from the next cycle. The load is ignored if that channel is currently in a transaction, or if it is being started in the same cycle.
- R3: When `txnStart` is high while `txnActive` is 0, the registers of channel `txnCh` are copied into the working counters and `txnActive` reads 1 from the next cycle. A `txnStart` while `txnActive` is 1 is ignored.
- R4: During a transaction, a `beatDone` with at least BEAT_BYTES (default 4) bytes remaining adds BEAT_BYTES to the working address and subtracts BEAT_BYTES from the working length.
- R5: A `beatDone` with fewer than BEAT_BYTES bytes remaining adds the remaining count to the address and sets the length to 0. A `beatDone` with a length of 0 changes nothing.
- R6: A channel's visible registers change only through its own load (R2) or through a write-back on `txnEnd`. Beats never change them.
- R7: A `txnEnd` during a transaction writes the working counters into the active channel's registers. A beat in that same cycle is included. The new values are visible and `txnActive` reads 0 from the next cycle.
- R8: `descDone` is high for exactly the one cycle in which a write-back with length 0 first becomes visible. `doneCh` then gives the channel that was written back.
- R9: `beatDone` and `txnEnd` have no effect while `txnActive` is 0.
- R10: A transaction on one channel leaves every other channel's registers untouched, and another channel may load a descriptor during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| descLoad | input | 1 | Descriptor fields valid for loading |
| descCh | input | CW | Channel that receives the descriptor |
| descAddr | input | AW | Buffer address field of the descriptor |
| descLen | input | LW | Buffer length field of the descriptor, in bytes |
| txnStart | input | 1 | Begin a transaction on `txnCh` |
| txnCh | input | CW | Channel that owns the starting transaction |
| beatDone | input | 1 | One data beat completed |
| txnEnd | input | 1 | Transaction finished, write back the counters |
| txnActive | output | 1 | Working counters are owned by a transaction |
| curAddr | output | NUM_CH x AW | Visible buffer address of each channel |
| curLen | output | NUM_CH x LW | Visible remaining length of each channel |
| descDone | output | 1 | One-cycle pulse: a write-back consumed the whole buffer |
| doneCh | output | CW | Channel of the latest write-back |

## Verification
On every cycle the assertions check the following:
- visible registers stay unchanged except through a load or a `txnEnd`;
- `txnActive` rises on an accepted start and falls on an accepted end;
- `descDone` lasts a single cycle and only coincides with a length of zero.

Only the bench's scenarios can show the counting itself. That covers the byte step for full beats, the clipped final beat, a beat arriving together with `txnEnd`, and the rejection of loads aimed at the busy channel. Those checks need the bench's model, which follows descriptor values across several transactions and channels.

// File: rtl/bufpos_pkg.sv
package bufpos_pkg;
  typedef struct packed {
    logic loadDesc;   // accepted descriptor load
    logic loadCnt;    // copy channel registers into working counters
    logic stepBeat;   // advance working counters by one beat
    logic writeBack;  // copy working counters into active channel
  } strobe_t;
endpackage

// File: rtl/bufpos_ctrl.sv
module bufpos_ctrl
  import bufpos_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          descLoad,
  input  logic [CW-1:0] descCh,
  input  logic          txnStart,
  input  logic [CW-1:0] txnCh,
  input  logic          beatDone,
  input  logic          txnEnd,
  output strobe_t       strb,
  output logic [CW-1:0] actCh,
  output logic          txnActive
);
  logic startOk, endOk, chanBusy, chanStarting;

  assign startOk      = txnStart && !txnActive;
  assign endOk        = txnEnd && txnActive;
  assign chanBusy     = txnActive && (descCh == actCh);
  assign chanStarting = startOk && (descCh == txnCh);

  always_comb begin
    strb.loadDesc  = descLoad && !chanBusy && !chanStarting;
    strb.loadCnt   = startOk;
    strb.stepBeat  = beatDone && txnActive;
    strb.writeBack = endOk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txnActive <= 1'b0;
      actCh     <= '0;
    end else if (startOk) begin
      txnActive <= 1'b1;
      actCh     <= txnCh;
    end else if (endOk) begin
      txnActive <= 1'b0;
    end
  end
endmodule

// File: rtl/bufpos_dpath.sv
module bufpos_dpath
  import bufpos_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CW         = 1,
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  strb,
  input  logic [CW-1:0]            descCh,
  input  logic [AW-1:0]            descAddr,
  input  logic [LW-1:0]            descLen,
  input  logic [CW-1:0]            txnCh,
  input  logic [CW-1:0]            actCh,
  output logic [NUM_CH-1:0][AW-1:0] curAddr,
  output logic [NUM_CH-1:0][LW-1:0] curLen,
  output logic                     descDone,
  output logic [CW-1:0]            doneCh
);
  localparam logic [LW-1:0] BEAT_L = LW'(BEAT_BYTES);

  logic [AW-1:0] cntAddr, nextAddr;
  logic [LW-1:0] cntLen, nextLen, stepBytes;

  // a beat moves a full bus word or whatever is left, whichever is less
  always_comb begin
    stepBytes = (cntLen < BEAT_L) ? cntLen : BEAT_L;
    nextAddr  = cntAddr;
    nextLen   = cntLen;
    if (strb.stepBeat) begin
      nextAddr = cntAddr + AW'(stepBytes);
      nextLen  = cntLen - stepBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntAddr <= '0;
      cntLen  <= '0;
    end else if (strb.loadCnt) begin
      cntAddr <= curAddr[txnCh];
      cntLen  <= curLen[txnCh];
    end else begin
      cntAddr <= nextAddr;
      cntLen  <= nextLen;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        curAddr[c] <= '0;
        curLen[c]  <= '0;
      end else if (strb.writeBack && actCh == CW'(c)) begin
        curAddr[c] <= nextAddr;
        curLen[c]  <= nextLen;
      end else if (strb.loadDesc && descCh == CW'(c)) begin
        curAddr[c] <= descAddr;
        curLen[c]  <= descLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      descDone <= 1'b0;
      doneCh   <= '0;
    end else begin
      descDone <= strb.writeBack && (nextLen == '0);
      if (strb.writeBack) doneCh <= actCh;
    end
  end
endmodule

// File: rtl/bufpos_tracker.sv
module bufpos_tracker
  import bufpos_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int BEAT_BYTES = 4,
  localparam int CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      descLoad,
  input  logic [CW-1:0]             descCh,
  input  logic [AW-1:0]             descAddr,
  input  logic [LW-1:0]             descLen,
  input  logic                      txnStart,
  input  logic [CW-1:0]             txnCh,
  input  logic                      beatDone,
  input  logic                      txnEnd,
  output logic                      txnActive,
  output logic [NUM_CH-1:0][AW-1:0] curAddr,
  output logic [NUM_CH-1:0][LW-1:0] curLen,
  output logic                      descDone,
  output logic [CW-1:0]             doneCh
);
  strobe_t       strb;
  logic [CW-1:0] actCh;

  bufpos_ctrl #(.NUM_CH(NUM_CH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .descLoad(descLoad), .descCh(descCh),
    .txnStart(txnStart), .txnCh(txnCh), .beatDone(beatDone), .txnEnd(txnEnd),
    .strb(strb), .actCh(actCh), .txnActive(txnActive)
  );

  bufpos_dpath #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW), .LW(LW),
                 .BEAT_BYTES(BEAT_BYTES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .descCh(descCh),
    .descAddr(descAddr), .descLen(descLen), .txnCh(txnCh), .actCh(actCh),
    .curAddr(curAddr), .curLen(curLen), .descDone(descDone), .doneCh(doneCh)
  );
endmodule

// File: rtl/bufpos_chk.sv
module bufpos_chk #(
  parameter int NUM_CH = 2,
  parameter int CW     = 1,
  parameter int AW     = 32,
  parameter int LW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      descLoad,
  input logic [CW-1:0]             descCh,
  input logic                      txnStart,
  input logic                      txnEnd,
  input logic                      txnActive,
  input logic [NUM_CH-1:0][AW-1:0] curAddr,
  input logic [NUM_CH-1:0][LW-1:0] curLen,
  input logic                      descDone,
  input logic [CW-1:0]             doneCh
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txnStart && !txnActive |=> txnActive);

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txnEnd && txnActive |=> !txnActive);

  p_done_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    descDone |-> curLen[doneCh] == '0);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    descDone |=> !descDone);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txnActive && !descLoad |=> $stable(curAddr) && $stable(curLen));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(descLoad && descCh == CW'(c)) && !txnEnd
        |=> $stable(curAddr[c]) && $stable(curLen[c]));
  end
endmodule

bind bufpos_tracker bufpos_chk #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .descLoad(descLoad), .descCh(descCh),
  .txnStart(txnStart), .txnEnd(txnEnd), .txnActive(txnActive),
  .curAddr(curAddr), .curLen(curLen), .descDone(descDone), .doneCh(doneCh)
);

// File: tb/sim_bufpos_tracker.sv
`timescale 1ns/1ps
module sim_bufpos_tracker;
  localparam int NCH = 2;
  localparam int AW  = 32;
  localparam int LW  = 16;
  localparam int BB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic descLoad = 1'b0, txnStart = 1'b0, beatDone = 1'b0, txnEnd = 1'b0;
  logic [0:0] descCh = '0, txnCh = '0;
  logic [AW-1:0] descAddr = '0;
  logic [LW-1:0] descLen = '0;
  logic txnActive, descDone;
  logic [0:0] doneCh;
  logic [NCH-1:0][AW-1:0] curAddr;
  logic [NCH-1:0][LW-1:0] curLen;

  always #2.5 clk = ~clk;  // 200 MHz

  bufpos_tracker #(.NUM_CH(NCH), .AW(AW), .LW(LW), .BEAT_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .descLoad(descLoad), .descCh(descCh),
    .descAddr(descAddr), .descLen(descLen), .txnStart(txnStart), .txnCh(txnCh),
    .beatDone(beatDone), .txnEnd(txnEnd), .txnActive(txnActive),
    .curAddr(curAddr), .curLen(curLen), .descDone(descDone), .doneCh(doneCh)
  );

  int checks = 0, errors = 0;
  string curReq = "R1";

  // behavioural reference model
  logic [AW-1:0] mAddr [NCH];
  int            mLen  [NCH];
  logic [AW-1:0] wAddr;
  int            wLen;
  bit            mAct, mDone;
  int            mCh, mDoneCh;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mAddr[i]) begin mAddr[i] = '0; mLen[i] = 0; end
      wAddr = '0; wLen = 0; mAct = 0; mDone = 0; mCh = 0; mDoneCh = 0;
    end else begin
      logic [AW-1:0] nA;
      int nL, st;
      bit wasAct;
      wasAct = mAct;
      nA = wAddr; nL = wLen;
      if (beatDone && wasAct) begin
        st = (wLen < BB) ? wLen : BB;
        nA = wAddr + st; nL = wLen - st;
      end
      mDone = 0;
      if (descLoad && !(wasAct && int'(descCh) == mCh)
          && !(txnStart && !wasAct && descCh == txnCh)) begin
        mAddr[descCh] = descAddr; mLen[descCh] = descLen;
      end
      if (txnEnd && wasAct) begin
        mAddr[mCh] = nA; mLen[mCh] = nL;
        mDone = (nL == 0); mDoneCh = mCh; mAct = 0;
      end
      if (txnStart && !wasAct) begin
        wAddr = mAddr[txnCh]; wLen = mLen[txnCh]; mAct = 1; mCh = txnCh;
      end else begin
        wAddr = nA; wLen = nL;
      end
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    checks++;
    begin
      bit bad;
      bad = (txnActive !== mAct) || (descDone !== mDone)
            || (mDone && int'(doneCh) != mDoneCh);
      for (int i = 0; i < NCH; i++)
        if (curAddr[i] !== mAddr[i] || int'(curLen[i]) != mLen[i]) bad = 1;
      if (bad) begin
        errors++;
        $display("FAIL %s cycle compare: act=%0b/%0b done=%0b/%0b a0=%h/%h l0=%0d/%0d a1=%h/%h l1=%0d/%0d",
                 curReq, txnActive, mAct, descDone, mDone, curAddr[0], mAddr[0],
                 curLen[0], mLen[0], curAddr[1], mAddr[1], curLen[1], mLen[1]);
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    descLoad = 0; txnStart = 0; beatDone = 0; txnEnd = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    curReq = "R1";
    chk("R1", "addr0", curAddr[0], 0); chk("R1", "len1", curLen[1], 0);
    chk("R1", "active", txnActive, 0);
    rst_n = 1; tick();

    curReq = "R2";
    descLoad = 1; descCh = 0; descAddr = 32'h1000; descLen = 10; tick();
    descCh = 1; descAddr = 32'h2000; descLen = 8; tick();
    idle(); tick();
    chk("R2", "addr0", curAddr[0], 32'h1000); chk("R2", "len1", curLen[1], 8);

    curReq = "R9";
    beatDone = 1; txnEnd = 1; tick(); idle(); tick();
    chk("R9", "len0", curLen[0], 10); chk("R9", "active", txnActive, 0);

    curReq = "R3";
    txnStart = 1; txnCh = 0; tick(); idle();
    chk("R3", "active", txnActive, 1);
    curReq = "R4";
    beatDone = 1; tick(); tick(); idle();
    txnStart = 1; txnCh = 1; tick(); idle();   // R3: ignored while busy
    descLoad = 1; descCh = 0; descAddr = 32'hDEAD0; descLen = 99; tick(); idle(); // R2: busy channel
    tick();
    chk("R6", "addr0 mid-txn", curAddr[0], 32'h1000);
    curReq = "R7";
    txnEnd = 1; tick(); idle();
    chk("R4", "addr0", curAddr[0], 32'h1008); chk("R4", "len0", curLen[0], 2);
    chk("R7", "active", txnActive, 0); chk("R8", "no done", descDone, 0);
    chk("R2", "rejected load", curLen[1], 8);

    curReq = "R5";
    txnStart = 1; txnCh = 0; tick(); idle();
    beatDone = 1; tick(); tick(); idle();
    txnEnd = 1; tick(); idle();
    chk("R5", "addr0", curAddr[0], 32'h100A); chk("R5", "len0", curLen[0], 0);
    chk("R8", "done", descDone, 1); chk("R8", "doneCh", doneCh, 0);
    tick(); chk("R8", "pulse width", descDone, 0);

    curReq = "R10";
    txnStart = 1; txnCh = 1;
    descLoad = 1; descCh = 0; descAddr = 32'h3000; descLen = 4; tick(); idle();
    beatDone = 1; txnEnd = 1; tick(); idle();
    chk("R7", "beat with end addr1", curAddr[1], 32'h2004);
    chk("R7", "len1", curLen[1], 4);
    chk("R10", "addr0", curAddr[0], 32'h3000); chk("R10", "len0", curLen[0], 4);

    curReq = "R4";
    for (int k = 0; k < 600; k++) begin
      descLoad = ($urandom_range(0, 5) == 0);
      descCh   = 1'($urandom_range(0, 1));
      descAddr = $urandom;
      descLen  = 16'($urandom_range(0, 40));
      txnStart = ($urandom_range(0, 3) == 0);
      txnCh    = 1'($urandom_range(0, 1));
      beatDone = ($urandom_range(0, 1) == 0);
      txnEnd   = ($urandom_range(0, 4) == 0);
      tick();
    end
    idle(); tick(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule